// File: doc/BRIEF.md
# Microwire EEPROM Master

This block runs single command transactions against a three-wire serial EEPROM holding 64 words of 16 bits. A host places a command code, a 6-bit word address and a 16-bit write word on its inputs, then pulses `start` for one cycle. The block raises chip select and shifts out a header made of a start bit, a 2-bit opcode and the address. For a read it then clocks 16 more bits and gathers them from the serial input. For a word write or a write-all it shifts out the data word. For the four special commands it places a selector in the two top address bits.

After a programming command the block drops chip select for one clock phase and raises it again. It then watches the serial input until the memory reports ready, or until a poll limit runs out. It then pulses `done`. The serial clock is built from the system clock. Each half period lasts `div+1` system cycles.

The controller has six states. `ST_IDLE` waits for a start with a valid code and goes to `ST_BIT_LO`. `ST_BIT_LO` presents the next bit with the clock low, and a phase tick moves it to `ST_BIT_HI`. `ST_BIT_HI` holds the clock high. At its tick it samples the input. It then returns to `ST_BIT_LO`, or after the last bit goes to `ST_CS_GAP` for programming commands and to `ST_FINISH` for the others. `ST_CS_GAP` keeps chip select low for one phase and then goes to `ST_POLL`. `ST_POLL` holds chip select high until the input reads 1 or the limit expires, and then goes to `ST_FINISH`. `ST_FINISH` pulses `done` and returns to `ST_IDLE`.

Top module: `mw_eeprom_master`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `cs`, `sclk`, `mosi` and `done` are all 0.
- R2: Every transaction begins with a 1 bit, followed MSB first by a 2-bit opcode and the 6-bit address. The opcodes are READ = 10, WRITE = 01 and ERASE = 11.
- R3: The special commands send opcode 00. The two top address bits select the command: 00 disables programming, 01 writes all words, 10 erases all words, 11 enables programming. The four low address bits are sent as 0. Disable, enable and erase-all frames are 9 clocks long.
- R4: WRITE and write-all frames carry the 16-bit word MSB first after the header, for 25 clocks in total. A READ frame is also 25 clocks long.
- R5: After a READ, `rdata` holds the last 16 bits sampled from `miso`, MSB first. The dummy bit sampled during the final address clock is discarded.
- R6: `sclk` is high only while `cs` is high. Each clock phase lasts `div+1` system cycles. `mosi` does not change while `sclk` is high.
- R7: After WRITE, ERASE, write-all or erase-all, `cs` goes low for exactly one phase and then high again. `done` follows only after `miso` has been seen high.
- R8: If `miso` stays low for `POLL_LIMIT` cycles of polling, the transaction ends with `done` and `timeout_err` set to 1. The next accepted start clears `timeout_err`.
- R9: `done` is a one-cycle pulse, and `busy` falls in the next cycle. An accepted start raises `busy` one cycle later. A start while `busy` is high is ignored.
- R10: Command codes: 0 read, 1 write, 2 erase, 3 enable programming, 4 disable programming, 5 write all, 6 erase all. Code 7 is ignored and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a command |
| cmd | input | 3 | Command code (R10) |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Word to write |
| div | input | DIV_W | Serial clock phase length minus one, in system cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word gathered by the last read |
| timeout_err | output | 1 | Ready poll expired on the last transaction |
| cs | output | 1 | Memory chip select, active high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data and ready flag from the memory |

## Verification
A wrong bit counter or a stale last-bit index shows as a frame of the wrong length. The memory model records the clock count when chip select falls, so this is seen at the end of the same transaction. A bad shift register or header builder shows as a wrong captured header, or as wrong data when a written word is read back, which shows one command later. An error in the poll state shows as `done` arriving while the modelled memory is still busy, or as a wrong `timeout_err`, and both are seen on the cycle of `done`.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int OP_W = 2;
    localparam int SEL_W = 2;

    typedef enum logic [2:0] {
        CMD_RD       = 3'd0,
        CMD_WR       = 3'd1,
        CMD_ER       = 3'd2,
        CMD_PROG_EN  = 3'd3,
        CMD_PROG_DIS = 3'd4,
        CMD_FILL     = 3'd5,
        CMD_CLEAR    = 3'd6,
        CMD_NONE     = 3'd7
    } cmd_e;

    localparam logic [OP_W-1:0] OP_SPECIAL = 2'b00;
    localparam logic [OP_W-1:0] OP_WRITE   = 2'b01;
    localparam logic [OP_W-1:0] OP_READ    = 2'b10;
    localparam logic [OP_W-1:0] OP_ERASE   = 2'b11;

    localparam logic [SEL_W-1:0] SEL_DIS  = 2'b00;
    localparam logic [SEL_W-1:0] SEL_FILL = 2'b01;
    localparam logic [SEL_W-1:0] SEL_CLR  = 2'b10;
    localparam logic [SEL_W-1:0] SEL_EN   = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BIT_LO = 3'd1,
        ST_BIT_HI = 3'd2,
        ST_CS_GAP = 3'd3,
        ST_POLL   = 3'd4,
        ST_FINISH = 3'd5
    } state_e;

    typedef struct packed {
        logic valid;
        logic is_read;
        logic is_prog;
        logic long_frame;
    } kind_t;

endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mw_poll_timer.sv
module mw_poll_timer #(
    parameter int LIMIT = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mw_frame_build.sv
module mw_frame_build
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic [2:0]                     cmd,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [1+OP_W+ADDR_W+DATA_W-1:0] frame,
    output kind_t                          kind
);

    localparam int PAD_W = ADDR_W - SEL_W;

    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] hdr_addr;

    always_comb begin
        op              = OP_SPECIAL;
        hdr_addr        = addr;
        kind.valid      = 1'b1;
        kind.is_read    = 1'b0;
        kind.is_prog    = 1'b0;
        kind.long_frame = 1'b0;
        unique case (cmd_e'(cmd))
            CMD_RD: begin
                op              = OP_READ;
                kind.is_read    = 1'b1;
                kind.long_frame = 1'b1;
            end
            CMD_WR: begin
                op              = OP_WRITE;
                kind.is_prog    = 1'b1;
                kind.long_frame = 1'b1;
            end
            CMD_ER: begin
                op           = OP_ERASE;
                kind.is_prog = 1'b1;
            end
            CMD_PROG_EN: begin
                hdr_addr = {SEL_EN, {PAD_W{1'b0}}};
            end
            CMD_PROG_DIS: begin
                hdr_addr = {SEL_DIS, {PAD_W{1'b0}}};
            end
            CMD_FILL: begin
                hdr_addr        = {SEL_FILL, {PAD_W{1'b0}}};
                kind.is_prog    = 1'b1;
                kind.long_frame = 1'b1;
            end
            CMD_CLEAR: begin
                hdr_addr     = {SEL_CLR, {PAD_W{1'b0}}};
                kind.is_prog = 1'b1;
            end
            CMD_NONE: begin
                kind.valid = 1'b0;
            end
        endcase
        if (kind.long_frame) begin
            frame = {1'b1, op, hdr_addr, wdata};
        end else begin
            frame = {1'b1, op, hdr_addr, {DATA_W{1'b0}}};
        end
    end

endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
    import mw_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 16,
    parameter int POLL_LIMIT = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  div,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              timeout_err,
    output logic              cs,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);

    localparam int HDR_W   = 1 + OP_W + ADDR_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(FRAME_W - 1);

    state_e             state, nstate;
    logic [FRAME_W-1:0] frame_c;
    kind_t              kind_c, kind_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   bitcnt_q, last_q;
    logic [DATA_W-1:0]  rx_q;
    logic               err_q;
    logic               tick, poll_expired;
    logic               phase_en, poll_en;
    logic               launch, last_bit;

    mw_frame_build #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .cmd   (cmd),
        .addr  (addr),
        .wdata (wdata),
        .frame (frame_c),
        .kind  (kind_c)
    );

    assign phase_en = (state == ST_BIT_LO) || (state == ST_BIT_HI) || (state == ST_CS_GAP);
    assign poll_en  = (state == ST_POLL);

    mw_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (phase_en),
        .div   (div),
        .tick  (tick)
    );

    mw_poll_timer #(
        .LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (poll_en),
        .expired (poll_expired)
    );

    assign launch   = (state == ST_IDLE) && start && kind_c.valid;
    assign last_bit = (bitcnt_q == last_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (launch) nstate = ST_BIT_LO;
            end
            ST_BIT_LO: begin
                if (tick) nstate = ST_BIT_HI;
            end
            ST_BIT_HI: begin
                if (tick) begin
                    if (!last_bit)          nstate = ST_BIT_LO;
                    else if (kind_q.is_prog) nstate = ST_CS_GAP;
                    else                     nstate = ST_FINISH;
                end
            end
            ST_CS_GAP: begin
                if (tick) nstate = ST_POLL;
            end
            ST_POLL: begin
                if (miso || poll_expired) nstate = ST_FINISH;
            end
            ST_FINISH: begin
                nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cs   = 1'b0;
        sclk = 1'b0;
        mosi = 1'b0;
        done = 1'b0;
        busy = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_BIT_LO: begin
                cs   = 1'b1;
                mosi = shreg_q[FRAME_W-1];
            end
            ST_BIT_HI: begin
                cs   = 1'b1;
                sclk = 1'b1;
                mosi = shreg_q[FRAME_W-1];
            end
            ST_CS_GAP: begin
                cs = 1'b0;
            end
            ST_POLL: begin
                cs = 1'b1;
            end
            ST_FINISH: begin
                done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            last_q   <= '0;
            kind_q   <= '0;
            rx_q     <= '0;
            err_q    <= 1'b0;
        end else begin
            if (launch) begin
                shreg_q  <= frame_c;
                bitcnt_q <= '0;
                last_q   <= kind_c.long_frame ? LAST_LONG : LAST_SHORT;
                kind_q   <= kind_c;
                err_q    <= 1'b0;
            end else if ((state == ST_BIT_HI) && tick) begin
                shreg_q  <= {shreg_q[FRAME_W-2:0], 1'b0};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (kind_q.is_read) begin
                    rx_q <= {rx_q[DATA_W-2:0], miso};
                end
            end
            if ((state == ST_POLL) && !miso && poll_expired) begin
                err_q <= 1'b1;
            end
        end
    end

    assign rdata       = rx_q;
    assign timeout_err = err_q;

endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [2:0] cmd,
    input logic       busy,
    input logic       done,
    input logic       timeout_err,
    input logic       cs,
    input logic       sclk,
    input logic       mosi
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cs && !sclk && !mosi && !done)); // R1

    AST_SCLK_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> cs); // R6

    AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R6

    AST_CS_RISE_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs) |-> !sclk); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R9

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cmd != 3'd7)) |=> busy); // R9

    AST_BAD_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cmd == 3'd7)) |=> !busy); // R10

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done); // R8

endmodule

bind mw_eeprom_master mw_eeprom_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cmd         (cmd),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .cs          (cs),
    .sclk        (sclk),
    .mosi        (mosi)
);

// File: tb/mw_eeprom_master_test.sv
module mw_eeprom_master_test;

    localparam int POLL_LIM = 300;
    localparam int BUSY_CYC = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [5:0]  addr = 6'd0;
    logic [15:0] wdata = 16'd0;
    logic [7:0]  div = 8'd1;
    logic        busy, done, timeout_err, cs, sclk, mosi;
    logic [15:0] rdata;
    logic        miso = 1'b0;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    mw_eeprom_master #(
        .POLL_LIMIT (POLL_LIM)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cmd         (cmd),
        .addr        (addr),
        .wdata       (wdata),
        .div         (div),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .timeout_err (timeout_err),
        .cs          (cs),
        .sclk        (sclk),
        .mosi        (mosi),
        .miso        (miso)
    );

    // ---------------- memory model ----------------
    logic [15:0] mem [64];
    int          m_n = 0;
    logic [24:0] m_frame = '0;
    int          m_busy = 0;
    bit          m_stuck = 0;
    bit          m_wen = 0;
    bit          m_rd = 0;
    logic [5:0]  m_raddr = '0;
    logic        m_bit = 1'b0;
    logic        cs_q = 1'b0, sclk_q = 1'b0;
    logic [24:0] last_frame = '0;
    int          last_n = 0;
    int          frames = 0;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    end

    always @(posedge clk) begin
        logic [8:0]  hdr;
        logic [15:0] dat;
        if (cs && !cs_q) begin
            m_n = 0;
            m_frame = '0;
        end
        if (cs && sclk && !sclk_q) begin
            m_n = m_n + 1;
            m_frame = {m_frame[23:0], mosi};
            if (m_n == 9 && m_frame[7:6] == 2'b10) begin
                m_rd = 1;
                m_raddr = m_frame[5:0];
                m_bit = 1'b0;
            end else if (m_rd && m_n >= 10 && m_n <= 25) begin
                m_bit = mem[m_raddr][25 - m_n];
            end
        end
        if (!cs && cs_q && m_n > 0) begin
            last_frame = m_frame;
            last_n = m_n;
            frames = frames + 1;
            m_rd = 0;
            hdr = (m_n == 25) ? m_frame[24:16] : m_frame[8:0];
            dat = m_frame[15:0];
            if (m_n == 9 && hdr[7:6] == 2'b00 && hdr[5:4] == 2'b11) m_wen = 1;
            if (m_n == 9 && hdr[7:6] == 2'b00 && hdr[5:4] == 2'b00) m_wen = 0;
            if (m_wen) begin
                if (m_n == 9 && hdr[7:6] == 2'b11) begin
                    mem[hdr[5:0]] = 16'hFFFF; m_busy = BUSY_CYC;
                end
                if (m_n == 9 && hdr[7:6] == 2'b00 && hdr[5:4] == 2'b10) begin
                    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
                    m_busy = BUSY_CYC;
                end
                if (m_n == 25 && hdr[7:6] == 2'b01) begin
                    mem[hdr[5:0]] = dat; m_busy = BUSY_CYC;
                end
                if (m_n == 25 && hdr[7:6] == 2'b00 && hdr[5:4] == 2'b01) begin
                    for (int i = 0; i < 64; i++) mem[i] = dat;
                    m_busy = BUSY_CYC;
                end
            end
        end else if (m_busy > 0 && !m_stuck) begin
            m_busy = m_busy - 1;
        end
        miso <= m_rd ? m_bit : (m_busy == 0);
        cs_q = cs;
        sclk_q = sclk;
    end

    // ---------------- helpers ----------------
    int r_cycles, r_gap, r_hi;
    bit r_saw_busy, r_ready, r_err, r_done_after, r_busy_after;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] c, input logic [5:0] a, input logic [15:0] d);
        int lowrun, hicnt;
        bit started;
        @(negedge clk);
        cmd = c; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_cycles = 0; r_gap = 0; r_hi = 0; r_saw_busy = 0;
        lowrun = 0; hicnt = 0; started = 0;
        while (!done && r_cycles < 5000) begin
            if (m_busy > 0) r_saw_busy = 1;
            if (cs) begin
                started = 1;
                if (lowrun > r_gap) r_gap = lowrun;
                lowrun = 0;
            end else if (started) begin
                lowrun++;
            end
            if (sclk) hicnt++;
            else if (hicnt > 0 && r_hi == 0) r_hi = hicnt;
            @(negedge clk);
            r_cycles++;
        end
        r_ready = (m_busy == 0);
        r_err = timeout_err;
        @(negedge clk);
        r_done_after = done;
        r_busy_after = busy;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 reset cs", cs, 0);
        chk("R1 reset sclk", sclk, 0);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset mosi", mosi, 0);
    endtask

    task automatic t_divider_and_disable();
        div = 8'd3;
        run_cmd(3'd4, 6'd0, 16'd0);
        chk("R6 high phase length div=3", r_hi, 4);
        chk("R3 disable header", last_frame, 25'h100);
        chk("R3 disable clocks", last_n, 9);
        chk("R9 done one cycle", r_done_after, 0);
        chk("R9 busy falls after done", r_busy_after, 0);
        div = 8'd1;
    endtask

    task automatic t_write_locked();
        run_cmd(3'd1, 6'd5, 16'h1234);
        run_cmd(3'd0, 6'd5, 16'd0);
        chk("R2 read header", last_frame[24:16], 9'h185);
        chk("R4 read clocks", last_n, 25);
        chk("R6 high phase length div=1", r_hi, 2);
        chk("R5 locked write left word erased", rdata, 16'hFFFF);
    endtask

    task automatic t_enable_write_read();
        run_cmd(3'd3, 6'd0, 16'd0);
        chk("R3 enable header", last_frame, 25'h130);
        run_cmd(3'd1, 6'd5, 16'hA5C3);
        chk("R2 R4 write frame", last_frame, {9'h145, 16'hA5C3});
        chk("R7 cs gap one phase", r_gap, 2);
        chk("R7 device was busy", r_saw_busy, 1);
        chk("R7 done only when ready", r_ready, 1);
        chk("R8 no timeout on ready", r_err, 0);
        run_cmd(3'd0, 6'd5, 16'd0);
        chk("R5 read back", rdata, 16'hA5C3);
        run_cmd(3'd1, 6'd63, 16'h8001);
        run_cmd(3'd0, 6'd63, 16'd0);
        chk("R5 read top address", rdata, 16'h8001);
    endtask

    task automatic t_erase();
        run_cmd(3'd2, 6'd5, 16'hDEAD);
        chk("R2 erase header", last_frame, 25'h1C5);
        chk("R3 erase clocks", last_n, 9);
        chk("R7 erase waited ready", r_ready && r_saw_busy, 1);
        run_cmd(3'd0, 6'd5, 16'd0);
        chk("R5 erased word", rdata, 16'hFFFF);
    endtask

    task automatic t_fill_clear();
        run_cmd(3'd5, 6'd21, 16'h3C5A);
        chk("R3 R4 fill frame", last_frame, {9'h110, 16'h3C5A});
        chk("R7 fill waited ready", r_ready && r_saw_busy, 1);
        run_cmd(3'd0, 6'd0, 16'd0);
        chk("R5 fill word 0", rdata, 16'h3C5A);
        run_cmd(3'd0, 6'd40, 16'd0);
        chk("R5 fill word 40", rdata, 16'h3C5A);
        run_cmd(3'd6, 6'd63, 16'd0);
        chk("R3 clear header", last_frame, 25'h120);
        chk("R3 clear clocks", last_n, 9);
        run_cmd(3'd0, 6'd40, 16'd0);
        chk("R5 cleared word", rdata, 16'hFFFF);
    endtask

    task automatic t_timeout();
        m_stuck = 1;
        run_cmd(3'd1, 6'd7, 16'h0F0F);
        chk("R8 timeout flagged", r_err, 1);
        chk("R8 poll ran to limit", (r_cycles >= POLL_LIM), 1);
        m_stuck = 0;
        repeat (BUSY_CYC + 5) @(negedge clk);
        run_cmd(3'd4, 6'd0, 16'd0);
        chk("R8 error cleared by next start", r_err, 0);
    endtask

    task automatic t_bad_code();
        int f0;
        f0 = frames;
        @(negedge clk);
        cmd = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 code 7 busy", busy, 0);
        chk("R10 code 7 cs", cs, 0);
        chk("R10 code 7 no frame", frames, f0);
    endtask

    task automatic t_start_while_busy();
        int f0, cyc;
        f0 = frames;
        @(negedge clk);
        cmd = 3'd0; addr = 6'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9 busy after start", busy, 1);
        repeat (8) @(negedge clk);
        cmd = 3'd1; addr = 6'd9; wdata = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        repeat (10) @(negedge clk);
        chk("R9 second start ignored busy", busy, 0);
        chk("R9 only one frame", frames, f0 + 1);
        chk("R9 frame was the read", last_frame[24:16], 9'h180);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divider_and_disable();
        t_write_locked();
        t_enable_write_read();
        t_erase();
        t_fill_clear();
        t_timeout();
        t_bad_code();
        t_start_while_busy();
        summary();
        $finish;
    end

endmodule